// File: doc/BRIEF.md
# NAND Flash Cycle Sequencer

This block sits between a register port and the raw pins of one NAND flash device. Software writes 32-bit command words into a small FIFO. The sequencer pops each word and turns it into bus cycles on the flash pins. A word asks for one of four cycle kinds:

- an address byte, strobed with ALE high;
- a command byte, strobed with CLE high;
- a burst of data bytes written to the device;
- a burst of data bytes read from the device.

Write data is taken from a byte stream fed by a DMA engine. Read data is handed to a second byte stream. Other bits of the word ask the block to wait for the device's ready/busy line, to mark the end of an operation, and to raise the interrupt when that operation ends.

Results are reported through a sticky status register. Software clears a status bit by writing a one to it at a separate offset. When a data stream stalls past a timeout, the block aborts the word and sets the command-error bit. While that bit is set, no further word is popped, so a driver that polls for success cannot be fooled by later words.

Top module: `nand_cycle_seq`

## Requirements
- R1: Word bits 17:16 select the cycle kind. Value 0 is an address cycle: one WE pulse with ALE high, CLE low, and the byte from word bits 7:0 on the bus. Value 1 is a command cycle: the same, but with CLE high and ALE low. CLE and ALE are never high together, and WE and RE are never low together.
- R2: Value 2 is a data write. It takes word bits 11:0 plus one bytes from the transmit stream, in arrival order, and gives each byte one WE pulse with CLE and ALE low.
- R3: Value 3 is a data read. It gives word bits 11:0 plus one RE pulses. Each pulse samples the flash bus, and the sampled bytes are offered in order on the receive stream. A byte held on that stream stays stable until it is accepted.
- R4: Chip enable (active low) goes low when a word is popped. It stays low across following words until a word with bit 18 (last cycle) finishes, and all strobes happen while it is low.
- R5: When word bit 19 is set, the word does not finish until the ready/busy input reads high, after a fixed busy delay. No completion bit is set before then.
- R6: Status bits set on completion:
  - bit 9 (command done) is set when a word with bit 18 finishes;
  - bit 6 is set at the end of a data write;
  - bit 7 is set at the end of a data read;
  - bit 12 is set at the end of either data kind.
- R7: The status register reads at offset 0x118. A write at offset 0x120 clears exactly the bits written as one. Bits written as zero keep their value.
- R8: If the transmit stream gives no byte for STALL_LIMIT cycles, the word is aborted: bits 11 and 1 are set and chip enable goes high. If the receive stream refuses a byte for STALL_LIMIT cycles, bits 11 and 5 are set in the same way.
- R9: While status bit 11 is set, no command word is popped and no strobe occurs. Clearing bit 11 resumes execution.
- R10: The interrupt output is high while bit 11 is set. It is also high while bit 9 is set, if the word that set bit 9 had bit 13 set. A completion without bit 13 leaves the interrupt low.
- R11: Words written at offset 0x0 run in write order. A write to a full FIFO is discarded. Status bit 10 reads one exactly while the FIFO has room.
- R12: After reset:
  - chip enable, WE and RE are high;
  - CLE and ALE are low;
  - the status register reads 0x400;
  - the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Status readback when reg_addr is 0x118, else zero |
| tx_valid | input | 1 | Transmit stream byte valid |
| tx_data | input | 8 | Transmit stream byte |
| tx_ready | output | 1 | Transmit byte accepted |
| rx_valid | output | 1 | Receive stream byte valid |
| rx_data | output | 8 | Receive stream byte |
| rx_ready | input | 1 | Receive byte accepted |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Bus byte driven to the flash |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_in | input | 8 | Bus byte from the flash |
| nf_rb_n | input | 1 | Ready (high) / busy (low) |
| irq | output | 1 | Interrupt request |

## Verification
Each byte takes STROBE_CYC + RECOVER_CYC cycles. A word adds one fetch cycle and one closing cycle. A ready wait adds BUSY_DELAY cycles plus however long the bench holds ready/busy low. A stall abort lands STALL_LIMIT cycles into the starved fetch or push.

The bench polls status with an explicit bound that covers these sums. For the requirements about ordering and waiting, it first samples inside the window where a result must not yet be present. Bus bytes are recorded at every WE rising edge, and receive bytes at every accepted handshake, so the ordering checks do not depend on exact cycle offsets.

// File: rtl/nfseq_pkg.sv
package nfseq_pkg;

   // Cycle kind encoded in command word bits 17:16
   typedef enum logic [1:0] {
      CY_ADDR = 2'd0,
      CY_CMD  = 2'd1,
      CY_WR   = 2'd2,
      CY_RD   = 2'd3
   } cyc_kind_e;

   typedef enum logic [2:0] {
      E_IDLE,
      E_FETCH,
      E_STROBE,
      E_PUSH,
      E_RECOVER,
      E_TWB,
      E_RDY,
      E_DONE
   } eng_state_e;

   // Command word field positions
   localparam int unsigned F_WFR  = 19;
   localparam int unsigned F_LAST = 18;
   localparam int unsigned F_KIND = 16;
   localparam int unsigned F_IWC  = 13;

   // Status bit positions
   localparam int unsigned ST_W          = 13;
   localparam int unsigned SB_TX_UNDER   = 1;
   localparam int unsigned SB_RX_OVER    = 5;
   localparam int unsigned SB_TX_END     = 6;
   localparam int unsigned SB_RX_END     = 7;
   localparam int unsigned SB_DONE       = 9;
   localparam int unsigned SB_ROOM       = 10;
   localparam int unsigned SB_ERR        = 11;
   localparam int unsigned SB_XFER_OVER  = 12;

   // Register offsets
   localparam int unsigned OFF_CMD  = 'h000;
   localparam int unsigned OFF_STAT = 'h118;
   localparam int unsigned OFF_CLR  = 'h120;

   function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/nf_cmd_fifo.sv
module nf_cmd_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("nf_cmd_fifo: DEPTH must be at least 2");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("nf_cmd_fifo: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   p_full_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (cnt == CW'(DEPTH)));

endmodule

// File: rtl/nf_cycle_engine.sv
module nf_cycle_engine
   import nfseq_pkg::*;
#(
   parameter int unsigned LEN_W       = 12,
   parameter int unsigned STROBE_CYC  = 2,
   parameter int unsigned RECOVER_CYC = 2,
   parameter int unsigned BUSY_DELAY  = 2,
   parameter int unsigned STALL_LIMIT = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        halt,
   input  logic        cmd_valid,
   input  logic [31:0] cmd_word,
   output logic        cmd_pop,
   input  logic        tx_valid,
   input  logic [7:0]  tx_data,
   output logic        tx_ready,
   output logic        rx_valid,
   output logic [7:0]  rx_data,
   input  logic        rx_ready,
   output logic        nf_ce_n,
   output logic        nf_cle,
   output logic        nf_ale,
   output logic        nf_we_n,
   output logic        nf_re_n,
   output logic [7:0]  nf_dq_out,
   output logic        nf_dq_oe,
   input  logic [7:0]  nf_dq_in,
   input  logic        nf_rb_n,
   output logic        ev_done,
   output logic        ev_iwc,
   output logic        ev_wr_end,
   output logic        ev_rd_end,
   output logic        ev_tx_starve,
   output logic        ev_rx_stall,
   output logic        ev_err
);
   localparam int unsigned TMAX = max3(STROBE_CYC, RECOVER_CYC, BUSY_DELAY);
   localparam int unsigned TW   = $clog2(TMAX + 1);
   localparam int unsigned SW   = $clog2(STALL_LIMIT + 1);

   if (STROBE_CYC < 1 || RECOVER_CYC < 1 || BUSY_DELAY < 1) begin : g_bad_timing
      $error("nf_cycle_engine: timing counts must be at least 1");
   end
   if (STALL_LIMIT < 2) begin : g_bad_stall
      $error("nf_cycle_engine: STALL_LIMIT must be at least 2");
   end
   if (LEN_W < 8 || LEN_W > F_IWC) begin : g_bad_len
      $error("nf_cycle_engine: LEN_W must lie in 8..13");
   end

   eng_state_e       st;
   cyc_kind_e        kind;
   logic             wfr_q, last_q, iwc_q, ce_on;
   logic [LEN_W-1:0] remain;
   logic [TW-1:0]    tcnt;
   logic [SW-1:0]    stall;
   logic [7:0]       dq_q, rd_q;
   logic             stall_hit, in_bus, is_data, unused_bits;

   assign unused_bits = ^{cmd_word[31:20], cmd_word[15:14], cmd_word[12:LEN_W]};

   assign stall_hit = (stall == SW'(STALL_LIMIT - 1));
   assign in_bus    = (st == E_STROBE) || (st == E_RECOVER) || (st == E_PUSH);
   assign is_data   = (kind == CY_WR) || (kind == CY_RD);

   assign cmd_pop   = (st == E_IDLE) && cmd_valid && !halt;
   assign tx_ready  = (st == E_FETCH);
   assign rx_valid  = (st == E_PUSH);
   assign rx_data   = rd_q;

   assign nf_ce_n   = !ce_on;
   assign nf_cle    = in_bus && (kind == CY_CMD);
   assign nf_ale    = in_bus && (kind == CY_ADDR);
   assign nf_we_n   = !((st == E_STROBE) && (kind != CY_RD));
   assign nf_re_n   = !((st == E_STROBE) && (kind == CY_RD));
   assign nf_dq_oe  = in_bus && (kind != CY_RD);
   assign nf_dq_out = dq_q;

   assign ev_tx_starve = (st == E_FETCH) && !tx_valid && stall_hit;
   assign ev_rx_stall  = (st == E_PUSH) && !rx_ready && stall_hit;
   assign ev_err       = ev_tx_starve || ev_rx_stall;
   assign ev_done      = (st == E_DONE) && last_q;
   assign ev_iwc       = (st == E_DONE) && last_q && iwc_q;
   assign ev_wr_end    = (st == E_DONE) && (kind == CY_WR);
   assign ev_rd_end    = (st == E_DONE) && (kind == CY_RD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= E_IDLE;
         kind   <= CY_ADDR;
         wfr_q  <= 1'b0;
         last_q <= 1'b0;
         iwc_q  <= 1'b0;
         ce_on  <= 1'b0;
         remain <= '0;
         tcnt   <= '0;
         stall  <= '0;
         dq_q   <= '0;
         rd_q   <= '0;
      end else begin
         unique case (st)
            E_IDLE: begin
               if (cmd_pop) begin
                  kind   <= cyc_kind_e'(cmd_word[F_KIND +: 2]);
                  wfr_q  <= cmd_word[F_WFR];
                  last_q <= cmd_word[F_LAST];
                  iwc_q  <= cmd_word[F_IWC];
                  remain <= cmd_word[LEN_W-1:0];
                  ce_on  <= 1'b1;
                  tcnt   <= '0;
                  stall  <= '0;
                  dq_q   <= cmd_word[7:0];
                  st     <= (cyc_kind_e'(cmd_word[F_KIND +: 2]) == CY_WR) ? E_FETCH : E_STROBE;
               end
            end
            E_FETCH: begin
               if (tx_valid) begin
                  dq_q <= tx_data;
                  tcnt <= '0;
                  st   <= E_STROBE;
               end else if (stall_hit) begin
                  ce_on <= 1'b0;
                  st    <= E_IDLE;
               end else begin
                  stall <= stall + 1'b1;
               end
            end
            E_STROBE: begin
               if (tcnt == TW'(STROBE_CYC - 1)) begin
                  tcnt <= '0;
                  if (kind == CY_RD) begin
                     rd_q  <= nf_dq_in;
                     stall <= '0;
                     st    <= E_PUSH;
                  end else begin
                     st <= E_RECOVER;
                  end
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            E_PUSH: begin
               if (rx_ready) begin
                  st <= E_RECOVER;
               end else if (stall_hit) begin
                  ce_on <= 1'b0;
                  st    <= E_IDLE;
               end else begin
                  stall <= stall + 1'b1;
               end
            end
            E_RECOVER: begin
               if (tcnt == TW'(RECOVER_CYC - 1)) begin
                  tcnt <= '0;
                  if (is_data && (remain != '0)) begin
                     remain <= remain - 1'b1;
                     stall  <= '0;
                     st     <= (kind == CY_WR) ? E_FETCH : E_STROBE;
                  end else begin
                     st <= wfr_q ? E_TWB : E_DONE;
                  end
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            E_TWB: begin
               if (tcnt == TW'(BUSY_DELAY - 1)) begin
                  tcnt <= '0;
                  st   <= E_RDY;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            E_RDY: begin
               if (nf_rb_n) st <= E_DONE;
            end
            E_DONE: begin
               if (last_q) ce_on <= 1'b0;
               st <= E_IDLE;
            end
            default: st <= E_IDLE;
         endcase
      end
   end

   p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nf_we_n && !nf_re_n));
   p_latch_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(nf_cle && nf_ale));
   p_strobe_in_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!nf_we_n || !nf_re_n) |-> !nf_ce_n);
   p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready && !ev_err) |=> (rx_valid && $stable(rx_data)));
   p_ready_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == E_DONE) && wfr_q) |-> $past(nf_rb_n));
   p_no_pop_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pop |-> !halt);

endmodule

// File: rtl/nf_irq_status.sv
module nf_irq_status
   import nfseq_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [ST_W-1:0] set_ev,
   input  logic            clr_wr,
   input  logic [ST_W-1:0] clr_mask,
   input  logic            fifo_room,
   input  logic            iwc_ev,
   output logic [ST_W-1:0] status,
   output logic            irq
);
   localparam logic [ST_W-1:0] LIVE_MASK = ST_W'(1) << SB_ROOM;

   logic [ST_W-1:0] sticky_q;
   logic [ST_W-1:0] clr_eff;
   logic            done_irq_q;

   assign clr_eff = clr_wr ? clr_mask : '0;

   for (genvar i = 0; i < ST_W; i++) begin : g_bit
      if (LIVE_MASK[i]) begin : g_live
         assign status[i] = fifo_room;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sticky_q[i] <= 1'b0;
            else        sticky_q[i] <= 1'b0;
         end
      end else begin : g_sticky
         assign status[i] = sticky_q[i];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         sticky_q[i] <= 1'b0;
            else if (set_ev[i]) sticky_q[i] <= 1'b1;
            else if (clr_eff[i]) sticky_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                done_irq_q <= 1'b0;
      else if (iwc_ev)           done_irq_q <= 1'b1;
      else if (clr_eff[SB_DONE]) done_irq_q <= 1'b0;
   end

   assign irq = (status[SB_DONE] && done_irq_q) || status[SB_ERR];

   p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_mask[SB_DONE] && !set_ev[SB_DONE]) |=> !status[SB_DONE]);
   p_err_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      status[SB_ERR] |-> irq);
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status[SB_ERR] && !(clr_wr && clr_mask[SB_ERR])) |=> status[SB_ERR]);

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
   import nfseq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned FIFO_DEPTH  = 4,
   parameter int unsigned LEN_W       = 12,
   parameter int unsigned STROBE_CYC  = 2,
   parameter int unsigned RECOVER_CYC = 2,
   parameter int unsigned BUSY_DELAY  = 2,
   parameter int unsigned STALL_LIMIT = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              tx_valid,
   input  logic [7:0]        tx_data,
   output logic              tx_ready,
   output logic              rx_valid,
   output logic [7:0]        rx_data,
   input  logic              rx_ready,
   output logic              nf_ce_n,
   output logic              nf_cle,
   output logic              nf_ale,
   output logic              nf_we_n,
   output logic              nf_re_n,
   output logic [7:0]        nf_dq_out,
   output logic              nf_dq_oe,
   input  logic [7:0]        nf_dq_in,
   input  logic              nf_rb_n,
   output logic              irq
);
   if (ADDR_W < 9) begin : g_bad_addr
      $error("nand_cycle_seq: ADDR_W too small for the register offsets");
   end

   logic            cmd_push, cmd_pop, cmd_empty, cmd_full;
   logic [31:0]     cmd_head;
   logic            clr_wr;
   logic [ST_W-1:0] status, set_ev;
   logic            ev_done, ev_iwc, ev_wr_end, ev_rd_end;
   logic            ev_tx_starve, ev_rx_stall, ev_err;
   logic            unused_wdata;

   assign cmd_push  = reg_wr && (reg_addr == ADDR_W'(OFF_CMD));
   assign clr_wr    = reg_wr && (reg_addr == ADDR_W'(OFF_CLR));
   assign reg_rdata = (reg_addr == ADDR_W'(OFF_STAT)) ? {{(32-ST_W){1'b0}}, status} : '0;
   assign unused_wdata = ^reg_wdata[31:ST_W];

   always_comb begin
      set_ev               = '0;
      set_ev[SB_TX_UNDER]  = ev_tx_starve;
      set_ev[SB_RX_OVER]   = ev_rx_stall;
      set_ev[SB_TX_END]    = ev_wr_end;
      set_ev[SB_RX_END]    = ev_rd_end;
      set_ev[SB_DONE]      = ev_done;
      set_ev[SB_ERR]       = ev_err;
      set_ev[SB_XFER_OVER] = ev_wr_end || ev_rd_end;
   end

   nf_cmd_fifo #(
      .WIDTH (32),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (cmd_push),
      .push_data (reg_wdata),
      .pop       (cmd_pop),
      .head      (cmd_head),
      .empty     (cmd_empty),
      .full      (cmd_full)
   );

   nf_cycle_engine #(
      .LEN_W       (LEN_W),
      .STROBE_CYC  (STROBE_CYC),
      .RECOVER_CYC (RECOVER_CYC),
      .BUSY_DELAY  (BUSY_DELAY),
      .STALL_LIMIT (STALL_LIMIT)
   ) u_engine (
      .clk          (clk),
      .rst_n        (rst_n),
      .halt         (status[SB_ERR]),
      .cmd_valid    (!cmd_empty),
      .cmd_word     (cmd_head),
      .cmd_pop      (cmd_pop),
      .tx_valid     (tx_valid),
      .tx_data      (tx_data),
      .tx_ready     (tx_ready),
      .rx_valid     (rx_valid),
      .rx_data      (rx_data),
      .rx_ready     (rx_ready),
      .nf_ce_n      (nf_ce_n),
      .nf_cle       (nf_cle),
      .nf_ale       (nf_ale),
      .nf_we_n      (nf_we_n),
      .nf_re_n      (nf_re_n),
      .nf_dq_out    (nf_dq_out),
      .nf_dq_oe     (nf_dq_oe),
      .nf_dq_in     (nf_dq_in),
      .nf_rb_n      (nf_rb_n),
      .ev_done      (ev_done),
      .ev_iwc       (ev_iwc),
      .ev_wr_end    (ev_wr_end),
      .ev_rd_end    (ev_rd_end),
      .ev_tx_starve (ev_tx_starve),
      .ev_rx_stall  (ev_rx_stall),
      .ev_err       (ev_err)
   );

   nf_irq_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_ev    (set_ev),
      .clr_wr    (clr_wr),
      .clr_mask  (reg_wdata[ST_W-1:0]),
      .fifo_room (!cmd_full),
      .iwc_ev    (ev_iwc),
      .status    (status),
      .irq       (irq)
   );

   p_done_needs_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done |-> !nf_ce_n);

endmodule

// File: tb/nand_cycle_seq_bench.sv
module nand_cycle_seq_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam int STALL      = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_valid, tx_ready, rx_valid;
   logic [7:0]  tx_data, rx_data;
   logic        rx_ready = 1'b1;
   logic        nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
   logic [7:0]  nf_dq_out, nf_dq_in;
   logic        nf_rb_n = 1'b1;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   // transmit feeder
   logic tx_en = 1'b0;
   int   tx_n = 0;
   function automatic logic [7:0] tx_pat(int k);
      return 8'h5A ^ 8'(k * 3);
   endfunction
   assign tx_valid = tx_en;
   assign tx_data  = tx_pat(tx_n);
   always @(posedge clk) if (tx_valid && tx_ready) tx_n <= tx_n + 1;

   // flash read model: byte advances on each RE rising edge
   int flash_n = 0;
   assign nf_dq_in = 8'hA0 + 8'(flash_n);
   always @(posedge nf_re_n) flash_n <= flash_n + 1;

   // receive capture
   logic [7:0] rx_mem [64];
   int rx_n = 0;
   always @(posedge clk) if (rx_valid && rx_ready && rx_n < 64) begin
      rx_mem[rx_n] <= rx_data;
      rx_n <= rx_n + 1;
   end

   // bus log at WE rising edges
   logic [7:0] log_dq  [64];
   logic       log_cle [64];
   logic       log_ale [64];
   int log_n = 0;
   always @(posedge nf_we_n) if (rst_n && log_n < 64) begin
      log_dq[log_n]  = nf_dq_out;
      log_cle[log_n] = nf_cle;
      log_ale[log_n] = nf_ale;
      log_n = log_n + 1;
   end

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_cycle_seq u_nand_cycle_seq (
      .clk (clk), .rst_n (rst_n),
      .reg_wr (reg_wr), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .tx_valid (tx_valid), .tx_data (tx_data), .tx_ready (tx_ready),
      .rx_valid (rx_valid), .rx_data (rx_data), .rx_ready (rx_ready),
      .nf_ce_n (nf_ce_n), .nf_cle (nf_cle), .nf_ale (nf_ale),
      .nf_we_n (nf_we_n), .nf_re_n (nf_re_n),
      .nf_dq_out (nf_dq_out), .nf_dq_oe (nf_dq_oe), .nf_dq_in (nf_dq_in),
      .nf_rb_n (nf_rb_n), .irq (irq)
   );

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(int kind, bit wfr, bit last, bit iwc, int low);
      return (32'(kind) << 16) | (32'(wfr) << 19) | (32'(last) << 18) | (32'(iwc) << 13) | 32'(low & 'hfff);
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 12'h118;
   endtask

   task automatic rd_stat(output logic [31:0] v);
      @(negedge clk);
      reg_addr = 12'h118;
      #1 v = reg_rdata;
   endtask

   task automatic wait_bit(input int b, input int limit, output bit seen);
      logic [31:0] v;
      seen = 0;
      for (int i = 0; i < limit && !seen; i++) begin
         rd_stat(v);
         if (v[b]) seen = 1;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R12
   task automatic t_reset();
      logic [31:0] v;
      rd_stat(v);
      check(v == 32'h400, "R12 status after reset", v, 32'h400);
      check({nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, irq} == 6'b111000,
            "R12 pins after reset", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, irq}, 6'b111000);
   endtask

   // R1 R4 R6 R7
   task automatic t_addr_cmd();
      int base;
      bit seen;
      logic [31:0] v;
      base = log_n;
      wr(12'h000, mk(0, 0, 0, 0, 'h3C));
      idle(20);
      rd_stat(v);
      check(nf_ce_n == 1'b0, "R4 CE held after non-last word", 32'(nf_ce_n), 0);
      check(v[9] == 1'b0, "R6 no done without last flag", v, 0);
      wr(12'h000, mk(1, 0, 1, 0, 'h1E5));
      wait_bit(9, 60, seen);
      check(seen, "R6 done after last word", 32'(seen), 1);
      check(nf_ce_n == 1'b1, "R4 CE released after last word", 32'(nf_ce_n), 1);
      check(log_n == base + 2, "R1 two strobes", 32'(log_n - base), 2);
      check(log_ale[base] && !log_cle[base] && log_dq[base] == 8'h3C, "R1 address cycle",
            {log_cle[base], log_ale[base], log_dq[base]}, {2'b01, 8'h3C});
      check(log_cle[base+1] && !log_ale[base+1] && log_dq[base+1] == 8'hE5, "R1 command cycle",
            {log_cle[base+1], log_ale[base+1], log_dq[base+1]}, {2'b10, 8'hE5});
      check(irq == 1'b0, "R10 no irq without iwc", 32'(irq), 0);
      wr(12'h120, 32'h0);
      rd_stat(v);
      check(v[9] == 1'b1, "R7 zero write keeps bit", v, 32'h600);
      wr(12'h120, 32'h200);
      rd_stat(v);
      check(v == 32'h400, "R7 one clears bit", v, 32'h400);
   endtask

   // R5
   task automatic t_ready_wait();
      bit seen;
      logic [31:0] v;
      nf_rb_n = 1'b0;
      wr(12'h000, mk(1, 1, 1, 0, 'h70));
      idle(40);
      rd_stat(v);
      check(v[9] == 1'b0, "R5 done held while busy", v, 32'h400);
      nf_rb_n = 1'b1;
      wait_bit(9, 10, seen);
      check(seen, "R5 done after ready", 32'(seen), 1);
      wr(12'h120, 32'h1FFF);
   endtask

   // R2 R6 R10
   task automatic t_write();
      int base, t0;
      bit seen, ok;
      logic [31:0] v;
      base = log_n; t0 = tx_n; tx_en = 1'b1;
      wr(12'h000, mk(2, 0, 1, 1, 4));
      wait_bit(9, 100, seen);
      tx_en = 1'b0;
      check(seen, "R2 write completes", 32'(seen), 1);
      check(log_n == base + 5, "R2 five bytes strobed", 32'(log_n - base), 5);
      ok = 1;
      for (int k = 0; k < 5; k++)
         if (log_dq[base+k] != tx_pat(t0 + k) || log_cle[base+k] || log_ale[base+k]) ok = 0;
      check(ok, "R2 byte order and latch lines", 32'(ok), 1);
      rd_stat(v);
      check(v == 32'h1640, "R6 write status bits", v, 32'h1640);
      check(irq == 1'b1, "R10 irq with iwc", 32'(irq), 1);
      wr(12'h120, 32'h1FFF);
      idle(1);
      check(irq == 1'b0, "R10 irq drops on clear", 32'(irq), 0);
   endtask

   // R3 R6 R10
   task automatic t_read();
      int r0, f0;
      bit seen, ok;
      logic [31:0] v;
      r0 = rx_n; f0 = flash_n;
      wr(12'h000, mk(3, 0, 1, 0, 3));
      wait_bit(9, 100, seen);
      check(seen && rx_n == r0 + 4, "R3 four bytes delivered", 32'(rx_n - r0), 4);
      ok = 1;
      for (int k = 0; k < 4; k++)
         if (rx_mem[r0+k] != 8'hA0 + 8'(f0 + k)) ok = 0;
      check(ok, "R3 read byte order", 32'(rx_mem[r0]), 32'(8'hA0 + 8'(f0)));
      rd_stat(v);
      check(v == 32'h1680, "R6 read status bits", v, 32'h1680);
      check(irq == 1'b0, "R10 no irq without iwc", 32'(irq), 0);
      wr(12'h120, 32'h1FFF);
   endtask

   // R8 R9
   task automatic t_stall();
      int base;
      bit seen;
      logic [31:0] v;
      tx_en = 1'b0;
      wr(12'h000, mk(2, 0, 1, 0, 2));
      wait_bit(11, STALL + 20, seen);
      rd_stat(v);
      check(seen && v[1], "R8 tx starve sets error", v, 32'hC02);
      check(nf_ce_n == 1'b1, "R8 CE released on abort", 32'(nf_ce_n), 1);
      check(irq == 1'b1, "R10 irq on error", 32'(irq), 1);
      base = log_n;
      wr(12'h000, mk(1, 0, 1, 0, 'h90));
      idle(30);
      check(log_n == base && nf_ce_n, "R9 halted while error set", 32'(log_n - base), 0);
      wr(12'h120, 32'h1FFF);
      wait_bit(9, 60, seen);
      check(seen && log_n == base + 1, "R9 resumes after clear", 32'(log_n - base), 1);
      wr(12'h120, 32'h1FFF);
      rx_ready = 1'b0;
      wr(12'h000, mk(3, 0, 1, 0, 0));
      wait_bit(11, STALL + 30, seen);
      rd_stat(v);
      check(seen && v[5] && !v[9], "R8 rx stall sets error", v, 32'hC20);
      rx_ready = 1'b1;
      wr(12'h120, 32'h1FFF);
   endtask

   // R11
   task automatic t_fifo();
      int base;
      bit seen;
      logic [31:0] v;
      bit ok;
      base = log_n;
      nf_rb_n = 1'b0;
      wr(12'h000, mk(1, 1, 1, 0, 'h11));
      idle(4);
      for (int k = 1; k <= DEPTH; k++) wr(12'h000, mk(1, 0, 1, 0, k));
      rd_stat(v);
      check(v[10] == 1'b0, "R11 room bit low when full", v, 0);
      wr(12'h000, mk(1, 0, 1, 0, 'h99));
      nf_rb_n = 1'b1;
      idle(80);
      check(log_n == base + 1 + DEPTH, "R11 extra write dropped", 32'(log_n - base), 32'(1 + DEPTH));
      ok = 1;
      for (int k = 1; k <= DEPTH; k++) if (log_dq[base+k] != 8'(k)) ok = 0;
      check(ok, "R11 words run in order", 32'(ok), 1);
      wait_bit(10, 4, seen);
      check(seen, "R11 room bit back", 32'(seen), 1);
      wr(12'h120, 32'h1FFF);
   endtask

   initial begin
      repeat (30000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_addr_cmd();
      t_ready_wait();
      t_write();
      t_read();
      t_stall();
      t_fifo();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule